// File: doc/BRIEF.md
# Clock-Line Trigger Command Encoder

This block puts trigger commands onto the same single wire that carries the 40 MHz bunch clock. When it has nothing to send, the wire is a plain clock. A command becomes a three-bit serial pattern, with one bit in each bunch period. A 1 bit keeps the normal clock pulse in its period. A 0 bit removes the high half of its period. Every pattern opens with a 1, so the first period of a command looks like an ordinary clock pulse. The receiving side finds a command from the pulses that go missing after it.

The block runs on a 2x clock that is phase-locked to the bunch clock. It follows the two halves of each bunch period with an internal phase flop, which reset places in the high half. There are four request inputs, each a one-cycle pulse: the level-1 accept and three auxiliary commands. Each input has a pending flag. A priority arbiter picks from the pending flags at each period boundary. A small state machine (IDLE, BIT0, BIT1, BIT2) then serialises the chosen pattern. It moves BIT0 to BIT1 to BIT2. From IDLE or BIT2 it goes to BIT0 if any request is pending, and to IDLE otherwise. A request that arrives while its own type is already pending is dropped and sets a sticky overflow bit for that type.

Top module: `clkline_trig_enc`

## Requirements
- R1: While reset is asserted, and in the first 2x cycle after it is released, `line_o` is 0 and `overflow_o` is 0.
- R2: With nothing pending, every bunch period is high in its first half and low in its second half. `line_o` is never high in two consecutive 2x cycles.
- R3: A level-1 accept request sends the high-half sequence 1,0,0 over three consecutive bunch periods.
- R4: `req_aux_i[0]` sends 1,1,0; `req_aux_i[1]` sends 1,0,1; `req_aux_i[2]` sends 1,1,1.
- R5: When several requests are pending at a period boundary, they are sent in this order: level-1 accept, then 110, then 101, then 111.
- R6: If a request is pending when a pattern ends, the next pattern starts in the very next bunch period, with no idle pulse in between.
- R7: Once a pattern has started, it runs for all three periods. A request that arrives during those periods is held and sent afterwards.
- R8: A request that arrives while a request of the same type is still pending sets that type's overflow bit and is dropped, so that pattern goes out only once. The bits of `overflow_o` are: bit 0 level-1 accept, bit 1 code 110, bit 2 code 101, bit 3 code 111.
- R9: An overflow bit, once set, stays set until reset.
- R10: A request sampled on the 2x edge that starts a bunch period goes out starting one full period later. That period is first sent as an ordinary idle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x_i | input | 1 | 2x clock, phase-locked to the bunch clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| req_l1a_i | input | 1 | One-cycle level-1 accept request |
| req_aux_i | input | 3 | One-cycle auxiliary requests (bit 0: 110, bit 1: 101, bit 2: 111) |
| line_o | output | 1 | Combined clock and command line |
| overflow_o | output | 4 | Sticky per-command overflow flags |

## Verification
The embedded assertions check four things on every cycle. The line never stays high across two halves. The opening half of a pattern is always high. A started pattern steps through all three bits. The arbiter never grants a lower-priority command while a higher one is pending, and an overflow bit never clears. Only the bench scenarios can show the bit values of each code, the order of back-to-back patterns, the latency from request to first period, and that a duplicate request really disappears from the line.

// File: rtl/clkenc_pkg.sv
package clkenc_pkg;

    localparam int NUM_CMD = 4;
    localparam int IDX_W   = $clog2(NUM_CMD);

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BIT0 = 2'd1,
        S_BIT1 = 2'd2,
        S_BIT2 = 2'd3
    } ser_state_t;

    // Second and third bits of a pattern; the first bit is always 1.
    // index 0: 100, 1: 110, 2: 101, 3: 111
    function automatic logic [1:0] pattern_tail(input logic [IDX_W-1:0] idx);
        logic [1:0] t;
        unique case (idx)
            2'd0: t = 2'b00;
            2'd1: t = 2'b10;
            2'd2: t = 2'b01;
            default: t = 2'b11;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/clkenc_phase.sv
module clkenc_phase (
    input  logic clk,
    input  logic rst_n,
    output logic low_half
);
    logic ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    assign low_half = ph_q;

    // R2: the phase alternates each cycle
    assert_phase_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        low_half |=> !low_half);
endmodule

// File: rtl/clkenc_arbiter.sv
module clkenc_arbiter #(
    parameter int N  = clkenc_pkg::NUM_CMD,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          any_pend,
    output logic [IW-1:0] sel,
    output logic [N-1:0]  ovf
);
    logic [N-1:0] pend_q;
    logic [N-1:0] grant;
    logic [N-1:0] ovf_q;

    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) sel = IW'(i);
        end
    end

    assign any_pend = |pend_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmd
            assign grant[g] = take && any_pend && (sel == IW'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_q[g] <= 1'b0;
                    ovf_q[g]  <= 1'b0;
                end else begin
                    pend_q[g] <= (pend_q[g] & ~grant[g]) | req[g];
                    if (req[g] && pend_q[g] && !grant[g]) ovf_q[g] <= 1'b1;
                end
            end

            if (g > 0) begin : g_prio
                // R5: never grant past a higher-priority pending command
                assert_prio_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    grant[g] |-> (pend_q[g-1:0] == '0));
            end
        end
    endgenerate

    assign ovf = ovf_q;

    assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9: overflow bits never clear
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        &(~$past(ovf_q) | ovf_q));
endmodule

// File: rtl/clkenc_serializer.sv
module clkenc_serializer
    import clkenc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             low_half,
    input  logic             any_pend,
    input  logic [IDX_W-1:0] sel,
    output logic             take,
    output logic             line_o
);
    ser_state_t st_q, st_d;
    logic [1:0] tail_q;
    logic       line_d;

    assign take = low_half && (st_q == S_IDLE || st_q == S_BIT2);

    always_comb begin
        st_d = st_q;
        if (low_half) begin
            unique case (st_q)
                S_IDLE, S_BIT2: st_d = any_pend ? S_BIT0 : S_IDLE;
                S_BIT0:         st_d = S_BIT1;
                S_BIT1:         st_d = S_BIT2;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            tail_q <= 2'b00;
        end else begin
            st_q <= st_d;
            if (take && any_pend) tail_q <= pattern_tail(sel);
        end
    end

    // Output process: high half carries the current bit, low half is 0
    always_comb begin
        line_d = 1'b0;
        if (low_half) begin
            unique case (st_d)
                S_IDLE, S_BIT0: line_d = 1'b1;
                S_BIT1:         line_d = (st_q == S_BIT0) ? tail_q[1] : 1'b0;
                S_BIT2:         line_d = tail_q[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_o <= 1'b0;
        else        line_o <= line_d;
    end

    // R2: never high in two consecutive half periods
    assert_no_double_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_o |=> !line_o);
    // R3: the first period of a pattern is an ordinary pulse
    assert_start_bit_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BIT0 && !low_half) |-> line_o);
    // R7: a started pattern is not cut short
    assert_no_interrupt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BIT0 && low_half) |=> (st_q == S_BIT1));
    assert_bit1_to_bit2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BIT1 && low_half) |=> (st_q == S_BIT2));
endmodule

// File: rtl/clkline_trig_enc.sv
module clkline_trig_enc
    import clkenc_pkg::*;
(
    input  logic       clk_2x_i,
    input  logic       rst_n_i,
    input  logic       req_l1a_i,
    input  logic [2:0] req_aux_i,
    output logic       line_o,
    output logic [3:0] overflow_o
);
    logic             low_half;
    logic             take;
    logic             any_pend;
    logic [IDX_W-1:0] sel;
    logic [NUM_CMD-1:0] req;

    assign req = {req_aux_i, req_l1a_i};

    clkenc_phase u_phase (
        .clk      (clk_2x_i),
        .rst_n    (rst_n_i),
        .low_half (low_half)
    );

    clkenc_arbiter #(.N(NUM_CMD)) u_arb (
        .clk      (clk_2x_i),
        .rst_n    (rst_n_i),
        .req      (req),
        .take     (take),
        .any_pend (any_pend),
        .sel      (sel),
        .ovf      (overflow_o)
    );

    clkenc_serializer u_ser (
        .clk      (clk_2x_i),
        .rst_n    (rst_n_i),
        .low_half (low_half),
        .any_pend (any_pend),
        .sel      (sel),
        .take     (take),
        .line_o   (line_o)
    );
endmodule

// File: tb/tb_clkline_trig_enc.sv
module tb_clkline_trig_enc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_l1a = 1'b0;
    logic [2:0] req_aux = 3'b000;
    logic       line;
    logic [3:0] ovf;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    clkline_trig_enc dut (
        .clk_2x_i   (clk),
        .rst_n_i    (rst_n),
        .req_l1a_i  (req_l1a),
        .req_aux_i  (req_aux),
        .line_o     (line),
        .overflow_o (ovf)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called just after an odd edge. rq = {aux[2:0], l1a}, driven for the first edge only.
    // bits lists the expected high-half values, first period in the most significant used bit.
    task automatic expect_seq(input logic [15:0] bits, input int np,
                              input logic [3:0] rq, input string tag);
        for (int p = 0; p < np; p++) begin
            if (p == 0) begin
                req_l1a = rq[0];
                req_aux = rq[3:1];
            end
            tick();
            req_l1a = 1'b0;
            req_aux = 3'b000;
            check(line == bits[np-1-p], tag, int'(line), int'(bits[np-1-p]));
            tick();
            check(line == 1'b0, tag, int'(line), 0);
        end
    endtask

    task automatic test_reset();
        repeat (3) tick();
        check(line == 1'b0 && ovf == 4'h0, "R1 in reset", int'({ovf, line}), 0);
        rst_n = 1'b1;
        tick();
        check(line == 1'b0 && ovf == 4'h0, "R1 after release", int'({ovf, line}), 0);
    endtask

    task automatic test_idle();
        expect_seq(16'h00FF, 8, 4'b0000, "R2 idle clock");
    endtask

    task automatic test_l1a();
        // R10: idle pulse first, then R3 pattern 100, then idle
        expect_seq(16'b1_100_1, 5, 4'b0001, "R3/R10 L1A");
    endtask

    task automatic test_aux();
        expect_seq(16'b1_110_1, 5, 4'b0010, "R4 aux0 110");
        expect_seq(16'b1_101_1, 5, 4'b0100, "R4 aux1 101");
        expect_seq(16'b1_111_1, 5, 4'b1000, "R4 aux2 111");
    endtask

    task automatic test_priority();
        // R5 order and R6 back-to-back
        expect_seq(16'b1_100_110_101_111_1, 14, 4'b1111, "R5/R6 all pending");
        check(ovf == 4'h0, "R8 no overflow", int'(ovf), 0);
    endtask

    task automatic test_no_interrupt();
        expect_seq(16'b11, 2, 4'b1000, "R7 start 111");
        expect_seq(16'b11_100_1, 6, 4'b0001, "R7 L1A held");
    endtask

    task automatic test_overflow();
        expect_seq(16'b11, 2, 4'b1000, "R8 start 111");
        expect_seq(16'b1, 1, 4'b0010, "R8 first 110 req");
        check(ovf == 4'h0, "R8 single pending", int'(ovf), 0);
        expect_seq(16'b1, 1, 4'b0010, "R8 dup 110 req");
        check(ovf == 4'b0010, "R8 overflow bit1", int'(ovf), 2);
        expect_seq(16'b110_11, 5, 4'b0000, "R8 sent once");
        expect_seq(16'h000F, 4, 4'b0000, "R9 idle");
        check(ovf == 4'b0010, "R9 sticky", int'(ovf), 2);
    endtask

    initial begin
        test_reset();
        test_idle();
        test_l1a();
        test_aux();
        test_priority();
        test_no_interrupt();
        test_overflow();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule